// File: doc/BRIEF.md
# Blowfish Block Round Engine

This block encrypts one 64-bit block with the Blowfish cipher. It uses a subkey array and four substitution tables that a host has already loaded. The four 256-entry tables share a single true dual-port synchronous RAM of 1024 words. Each port reads one word per clock, so the engine gets two table entries per cycle. A round needs four entries, and the engine schedules its reads around that limit.

The host loads the tables and the 18 subkeys through a simple write port while the engine is idle. It then pulses `start` with a 64-bit plaintext. `busy` stays high while the sixteen rounds run. `done` pulses for one cycle when the ciphertext appears on `dout`, and `dout` holds that value until the next block completes.

Two parameters shape the timing:
- `OVERLAP` chooses the round schedule:
  - The base schedule issues two paired table fetches, then runs a combine cycle.
  - The overlapped schedule issues the next round's first pair during that combine cycle.
- `RD_LAT` sets the RAM read latency to one or two cycles. The sequencer adds wait cycles so the result does not change.

Top module: `bf_round_engine`

## Requirements
- R1: After synchronous reset, `busy` and `done` are 0 and `dout` is all zeros.
- R2: The engine produces the Blowfish encryption of `din`, computed as follows:
  - The round function is F(x) = ((T0[x[31:24]] + T1[x[23:16]]) XOR T2[x[15:8]]) + T3[x[7:0]], with sums taken modulo 2^32.
  - Each of sixteen rounds sets L ^= K[i], then R ^= F(L), then swaps the halves.
  - After the last round, the final swap is undone, R ^= K[16] and L ^= K[17].
  - The output is `{L, R}`, with L taken from `din[63:32]` and R from `din[31:0]`.
- R3: A write with `wr_tgt`=0 stores `wr_data` into table `wr_addr[9:8]` at entry `wr_addr[7:0]`. A write with `wr_tgt`=1 stores it into subkey K[`wr_addr[4:0]`], for indices 0 to 17.
- R4: With `OVERLAP`=0, `done` rises 16*(`RD_LAT`+2) clock edges after the edge that accepts `start`.
- R5: With `OVERLAP`=1, `done` rises 16*(`RD_LAT`+1)+1 clock edges after the edge that accepts `start`.
- R6: `done` is high for exactly one cycle per block. `dout` changes only at the edge that raises `done`.
- R7: `busy` goes high the cycle after `start` is accepted and drops when `done` rises. A `start` that arrives while `busy` is high is ignored.
- R8: Host writes are ignored while `busy` is high, so a block in flight and the blocks after it use the tables and subkeys as they were at start.
- R9: Read latencies of one and two cycles give the same ciphertext in both schedules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin encrypting `din` (accepted when idle) |
| din | input | 64 | Plaintext block, left half in the upper 32 bits |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle pulse: `dout` is valid |
| dout | output | 64 | Ciphertext block, held until the next completion |
| wr_en | input | 1 | Host write strobe |
| wr_tgt | input | 1 | 0 selects a table entry, 1 selects a subkey |
| wr_addr | input | 10 | Table and entry, or subkey index in bits 4:0 |
| wr_data | input | 32 | Word to store |

## Verification
The bench builds four instances side by side, covering every combination of `OVERLAP` 0/1 and `RD_LAT` 1/2. They share the same stimulus, so each ciphertext is checked against an arithmetic model of the cipher, and each completion latency is checked against its own closed form in one run. It loads two full pseudo-random sets of tables and subkeys. This exercises all four read-address slices and every subkey index across many plaintexts. The block latencies are 48, 33, 64 and 49 cycles, so one disturbance window falls while all four instances are busy. That window carries writes and stray start pulses.

// File: rtl/bf_pkg.sv
package bf_pkg;
    localparam int ROUNDS     = 16;
    localparam int KEY_WORDS  = ROUNDS + 2;
    localparam int TBL_COUNT  = 4;
    localparam int TBL_DEPTH  = 256;
    localparam int TBL_WORDS  = TBL_COUNT * TBL_DEPTH;
    localparam int TBL_AW     = $clog2(TBL_WORDS);
    localparam int KEY_AW     = $clog2(KEY_WORDS);
    localparam int ROUND_W    = $clog2(ROUNDS);

    typedef logic [31:0] word_t;

    typedef struct packed {
        word_t l;
        word_t r;
    } halves_t;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_RUN  = 1'b1
    } seq_state_t;

    function automatic logic [TBL_AW-1:0] tbl_addr(input logic [1:0] box,
                                                   input logic [7:0] idx);
        return {box, idx};
    endfunction

    function automatic word_t mix_f(input word_t t0, input word_t t1,
                                    input word_t t2, input word_t t3);
        return ((t0 + t1) ^ t2) + t3;
    endfunction
endpackage

// File: rtl/bf_sbox_ram.sv
module bf_sbox_ram #(
    parameter int DEPTH = 1024,
    parameter int WIDTH = 32,
    parameter int LAT   = 1,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we_a,
    input  logic [AW-1:0]    addr_a,
    input  logic [WIDTH-1:0] wdata_a,
    output logic [WIDTH-1:0] rdata_a,
    input  logic [AW-1:0]    addr_b,
    output logic [WIDTH-1:0] rdata_b
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [WIDTH-1:0] pipe_a [LAT];
    logic [WIDTH-1:0] pipe_b [LAT];

    always_ff @(posedge clk) begin
        if (we_a) mem[addr_a] <= wdata_a;
        pipe_a[0] <= mem[addr_a];
        pipe_b[0] <= mem[addr_b];
        for (int s = 1; s < LAT; s++) begin
            pipe_a[s] <= pipe_a[s-1];
            pipe_b[s] <= pipe_b[s-1];
        end
    end

    assign rdata_a = pipe_a[LAT-1];
    assign rdata_b = pipe_b[LAT-1];
endmodule

// File: rtl/bf_parray.sv
module bf_parray #(
    parameter int N   = 18,
    parameter int W   = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic          lock,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);
    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we && !lock && (int'(waddr) < N)) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata_a = (int'(raddr_a) < N) ? regs[raddr_a] : '0;
    assign rdata_b = (int'(raddr_b) < N) ? regs[raddr_b] : '0;

    // R8
    hold_while_locked_chk: assert property (@(posedge clk) disable iff (rst)
        lock |=> ($stable(regs[0]) && $stable(regs[N-1]) && $stable(regs[N/2])));
endmodule

// File: rtl/bf_round_engine.sv
module bf_round_engine
    import bf_pkg::*;
#(
    parameter bit OVERLAP = 1'b0,
    parameter int RD_LAT  = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [63:0] din,
    output logic        busy,
    output logic        done,
    output logic [63:0] dout,
    input  logic        wr_en,
    input  logic        wr_tgt,
    input  logic [9:0]  wr_addr,
    input  logic [31:0] wr_data
);
    localparam int CAP_PH = RD_LAT;
    localparam int CMP_PH = RD_LAT + 1;
    localparam int PH_W   = $clog2(CMP_PH + 1);

    seq_state_t             state_q;
    halves_t                xs_q;
    logic [ROUND_W-1:0]     round_q;
    logic [PH_W-1:0]        ph_q;
    word_t                  cap0_q, cap1_q;
    logic                   done_q;
    logic [63:0]            dout_q;

    logic                   run, at_cmp, last;
    logic [TBL_AW-1:0]      ram_addr_a, ram_addr_b;
    word_t                  ram_rd_a, ram_rd_b;
    logic [KEY_AW-1:0]      k_idx_a, k_idx_b;
    word_t                  k_a, k_b;
    word_t                  f_val, nxt_l;

    assign run    = (state_q == SQ_RUN);
    assign at_cmp = run && (ph_q == PH_W'(CMP_PH));
    assign last   = at_cmp && (round_q == ROUND_W'(ROUNDS - 1));

    assign k_idx_a = run ? (KEY_AW'(round_q) + KEY_AW'(1)) : '0;
    assign k_idx_b = KEY_AW'(KEY_WORDS - 1);

    assign f_val = mix_f(cap0_q, cap1_q, ram_rd_a, ram_rd_b);
    assign nxt_l = xs_q.r ^ f_val ^ k_a;

    always_comb begin
        if (!run) begin
            ram_addr_a = wr_addr;
            ram_addr_b = '0;
        end else if (OVERLAP && at_cmp && !last) begin
            ram_addr_a = tbl_addr(2'd0, nxt_l[31:24]);
            ram_addr_b = tbl_addr(2'd1, nxt_l[23:16]);
        end else if (ph_q == PH_W'(1)) begin
            ram_addr_a = tbl_addr(2'd2, xs_q.l[15:8]);
            ram_addr_b = tbl_addr(2'd3, xs_q.l[7:0]);
        end else begin
            ram_addr_a = tbl_addr(2'd0, xs_q.l[31:24]);
            ram_addr_b = tbl_addr(2'd1, xs_q.l[23:16]);
        end
    end

    bf_sbox_ram #(.DEPTH(TBL_WORDS), .WIDTH(32), .LAT(RD_LAT)) u_tables (
        .clk     (clk),
        .we_a    (wr_en && !wr_tgt && !run),
        .addr_a  (ram_addr_a),
        .wdata_a (wr_data),
        .rdata_a (ram_rd_a),
        .addr_b  (ram_addr_b),
        .rdata_b (ram_rd_b)
    );

    bf_parray #(.N(KEY_WORDS), .W(32)) u_keys (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_en && wr_tgt),
        .lock    (run),
        .waddr   (wr_addr[KEY_AW-1:0]),
        .wdata   (wr_data),
        .raddr_a (k_idx_a),
        .raddr_b (k_idx_b),
        .rdata_a (k_a),
        .rdata_b (k_b)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            xs_q    <= '0;
            round_q <= '0;
            ph_q    <= '0;
            cap0_q  <= '0;
            cap1_q  <= '0;
            done_q  <= 1'b0;
            dout_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (!run) begin
                if (start) begin
                    xs_q.l  <= din[63:32] ^ k_a;
                    xs_q.r  <= din[31:0];
                    round_q <= '0;
                    ph_q    <= '0;
                    state_q <= SQ_RUN;
                end
            end else begin
                if (ph_q == PH_W'(CAP_PH)) begin
                    cap0_q <= ram_rd_a;
                    cap1_q <= ram_rd_b;
                end
                if (at_cmp) begin
                    xs_q.l <= nxt_l;
                    xs_q.r <= xs_q.l;
                    if (last) begin
                        dout_q  <= {xs_q.l ^ k_b, nxt_l};
                        done_q  <= 1'b1;
                        state_q <= SQ_IDLE;
                    end else begin
                        round_q <= round_q + ROUND_W'(1);
                        ph_q    <= OVERLAP ? PH_W'(1) : PH_W'(0);
                    end
                end else begin
                    ph_q <= ph_q + PH_W'(1);
                end
            end
        end
    end

    assign busy = run;
    assign done = done_q;
    assign dout = dout_q;

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    // R6
    dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done_q |-> $stable(dout_q));
    // R7
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !run);
    // R7
    busy_persist_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !last) |=> run);
    // R4
    phase_range_chk: assert property (@(posedge clk) disable iff (rst)
        ph_q <= PH_W'(CMP_PH));
endmodule

// File: tb/bf_round_engine_test.sv
module bf_round_engine_test;
    import bf_pkg::*;

    localparam int NCFG = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [63:0] din = '0;
    logic        wr_en = 1'b0;
    logic        wr_tgt = 1'b0;
    logic [9:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;

    logic [63:0] dout_w [NCFG];
    logic        busy_w [NCFG];
    logic        done_w [NCFG];

    logic [31:0] mk [KEY_WORDS];
    logic [31:0] mt [TBL_WORDS];

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    for (genvar g = 0; g < NCFG; g++) begin : cfg
        bf_round_engine #(.OVERLAP(g % 2 == 1), .RD_LAT(1 + g / 2)) uut (
            .clk(clk), .rst(rst), .start(start), .din(din),
            .busy(busy_w[g]), .done(done_w[g]), .dout(dout_w[g]),
            .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_addr(wr_addr), .wr_data(wr_data)
        );
    end

    function automatic int exp_lat(input int k);
        int lat = 1 + k / 2;
        return (k % 2 == 1) ? 16 * (lat + 1) + 1 : 16 * (lat + 2);
    endfunction

    function automatic logic [31:0] hashw(input logic [31:0] seed, input logic [31:0] k);
        logic [31:0] x = k * 32'h9E3779B9 + seed;
        x = x ^ (x >> 15);
        x = x * 32'h2C1B3C6D;
        x = x ^ (x >> 12);
        x = x * 32'h297A2D39;
        return x ^ (x >> 15);
    endfunction

    function automatic logic [31:0] model_f(input logic [31:0] x);
        return ((mt[{2'd0, x[31:24]}] + mt[{2'd1, x[23:16]}]) ^ mt[{2'd2, x[15:8]}])
               + mt[{2'd3, x[7:0]}];
    endfunction

    function automatic logic [63:0] model_enc(input logic [63:0] v);
        logic [31:0] l = v[63:32];
        logic [31:0] r = v[31:0];
        logic [31:0] t;
        for (int i = 0; i < ROUNDS; i++) begin
            l = l ^ mk[i];
            r = r ^ model_f(l);
            t = l; l = r; r = t;
        end
        t = l; l = r; r = t;
        r = r ^ mk[16];
        l = l ^ mk[17];
        return {l, r};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // R3: table writes use wr_tgt=0 and {box, entry} addressing; subkeys use wr_tgt=1
    task automatic load_tables(input logic [31:0] seed);
        wr_en = 1'b1;
        wr_tgt = 1'b0;
        for (int k = 0; k < TBL_WORDS; k++) begin
            mt[k] = hashw(seed, k);
            wr_addr = 10'(k);
            wr_data = mt[k];
            @(negedge clk);
        end
        wr_tgt = 1'b1;
        for (int k = 0; k < KEY_WORDS; k++) begin
            mk[k] = hashw(seed ^ 32'h5A5A0F0F, k + 7000);
            wr_addr = 10'(k);
            wr_data = mk[k];
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    task automatic run_block(input logic [63:0] v, input bit disturb, input string req);
        int first [NCFG];
        int cnt [NCFG];
        logic [63:0] exp;
        exp = model_enc(v);
        for (int k = 0; k < NCFG; k++) begin first[k] = 0; cnt[k] = 0; end
        din = v;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int n = 1; n <= 72; n++) begin
            @(negedge clk);
            for (int k = 0; k < NCFG; k++) begin
                if (done_w[k]) begin
                    cnt[k]++;
                    if (first[k] == 0) first[k] = n;
                end
                if (n == 1) check(busy_w[k] == 1'b1, "R7 busy after start", 64'(busy_w[k]), 64'd1);
            end
            if (disturb) begin
                // R8 and R7: writes and start pulses while all instances are busy
                wr_en   = (n >= 1 && n <= 20);
                wr_tgt  = n[0];
                wr_addr = 10'((n * 37) % TBL_WORDS);
                if (n[0]) wr_addr = 10'(n % KEY_WORDS);
                wr_data = 32'hDEAD0000 | 32'(n);
                start   = (n == 5 || n == 9);
                din     = ~v;
            end
        end
        wr_en = 1'b0;
        start = 1'b0;
        for (int k = 0; k < NCFG; k++) begin
            check(first[k] == exp_lat(k), (k % 2 == 1) ? "R5 latency" : "R4 latency",
                  64'(first[k]), 64'(exp_lat(k)));
            check(cnt[k] == 1, "R6 R7 single done", 64'(cnt[k]), 64'd1);
            check(dout_w[k] == exp, req, dout_w[k], exp);
            check(busy_w[k] == 1'b0, "R7 idle after done", 64'(busy_w[k]), 64'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int k = 0; k < NCFG; k++) begin
            check(busy_w[k] == 1'b0 && done_w[k] == 1'b0, "R1 reset flags",
                  {62'd0, busy_w[k], done_w[k]}, 64'd0);
            check(dout_w[k] == 64'd0, "R1 reset dout", dout_w[k], 64'd0);
        end

        load_tables(32'h13579BDF);
        run_block(64'h0000000000000000, 1'b0, "R2 R3 R9 zero block");
        run_block(64'hFFFFFFFFFFFFFFFF, 1'b0, "R2 R9 ones block");
        run_block(64'h0123456789ABCDEF, 1'b0, "R2 R9 ascending");
        run_block(64'h8000000000000000, 1'b0, "R2 R9 top bit");
        run_block(64'h0000000000000001, 1'b0, "R2 R9 low bit");
        for (int i = 0; i < 12; i++)
            run_block({hashw(32'hA1, i), hashw(32'hB2, i)}, 1'b0, "R2 R9 sweep A");

        load_tables(32'hCAFEF00D);
        run_block(64'hFEDCBA9876543210, 1'b0, "R2 R3 table set B");
        for (int i = 0; i < 8; i++)
            run_block({hashw(32'hC3, i), hashw(32'hD4, i)}, 1'b0, "R2 R9 sweep B");

        run_block(64'h1122334455667788, 1'b1, "R8 R7 disturbed block");
        run_block(64'h1122334455667788, 1'b0, "R8 after disturbance");
        run_block(64'h0F0F0F0FF0F0F0F0, 1'b0, "R8 tables intact");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule